// File: doc/BRIEF.md
# SPI Master Controller with Memory-Mapped Configuration

This block is a serial peripheral interface master. A host configures and runs it through a 32-bit memory-mapped register bus. Each access uses a simple strobe, cycle and write-enable handshake, and the block returns a one-cycle acknowledge. A 64-bit data register holds the word to send. As bits go out on MOSI, the bits sampled from MISO are written back into the same register. When the transfer ends, the register holds the received word, and the host reads it from the same offsets it used to load the transmit word.

The host programs the following through the registers:
- the number of bits per transfer, from 1 to 64;
- whether the word goes out starting from its top bit or its bottom bit;
- which SCLK edge launches MOSI, and separately which edge captures MISO;
- the SCLK rate, through a divider register;
- which of eight active-low select lines are driven during a transfer.

Setting the go bit starts a transfer. The go bit reads back as busy until the last edge. When it clears, an optional interrupt rises and stays high until the next bus access completes.

Top module: `spi_ctl_master`

## Requirements
- R1: After reset, SCLK is low, all select outputs are high, the interrupt and acknowledge are low, and the control, divider and select registers read as zero.
- R2: Registers are decoded from byte addresses with bits 1:0 equal to zero. The low data word is at 0x00, the high data word at 0x04, control at 0x08, the divider at 0x0C and select at 0x10. A misaligned or unmapped read returns zero. Every strobed access is acknowledged for exactly one cycle, in the cycle after the strobe.
- R3: SCLK idles low. Each SCLK half-period lasts (divider+1)×2 system clocks. A transfer of N bits produces exactly N rising SCLK edges and ends with SCLK low.
- R4: The length field in control bits 8:3 gives N, the number of bits shifted in each direction. A field value of 0 means 64 bits.
- R5: With control bit 9 at 0, transmit bit N-1 goes out first, and the j-th received bit is stored at position N-1-j. Data bits at N and above keep their transmit value.
- R6: With control bit 9 at 1, transmit bit 0 goes out first, and the j-th received bit is stored at position j.
- R7: Control bit 2 selects the MOSI launch edge. With the bit at 0, MOSI changes on rising SCLK edges, and the first bit appears at the first rising edge. With the bit at 1, the first bit is on MOSI before the first rising edge, and later bits change on falling edges.
- R8: Control bit 1 selects the MISO capture edge. With the bit at 0, MISO is captured on rising SCLK edges; with the bit at 1, on falling edges.
- R9: Writing control with bit 0 set while idle starts a transfer. Control bit 0 reads 1 while the transfer runs and returns to 0 by itself once the last SCLK edge has passed.
- R10: Select output k is low only while a transfer runs and bit k of the select register is 1. At all other times it is high.
- R11: With control bit 10 set, the interrupt rises in the cycle where busy falls. It goes low one clock after the acknowledge of the next bus access. With control bit 10 clear, the interrupt stays low.
- R12: While busy, writes to the data words, the divider and control are ignored. Writes to the select register still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busWe | input | 1 | Write enable (1 = write, 0 = read) |
| busStb | input | 1 | Access strobe |
| busCyc | input | 1 | Bus cycle valid |
| busRdData | output | 32 | Read data, valid while busAck is high |
| busAck | output | 1 | One-cycle access acknowledge |
| irq | output | 1 | End-of-transfer interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| selN | output | 8 | Active-low slave selects |

## Verification
The bench uses the default parameters: a 32-bit bus, a 16-bit divider and eight selects. These give a 64-bit data register, so the full-length case (field value 0) and the 1-bit case can both be reached through the two data words. Small divider values (0 to 5) keep even a 64-bit transfer within a few hundred clocks. At the same time, half-period widths of 2, 4, 6 and 12 clocks can be measured directly. A bench slave follows each launch and capture edge pairing, so the bench checks every combination of edge selection, bit order and length against independently computed bit sequences.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  // Word index of each register (byte address bits 4:2)
  localparam logic [2:0] REG_DLO  = 3'd0;
  localparam logic [2:0] REG_DHI  = 3'd1;
  localparam logic [2:0] REG_CTRL = 3'd2;
  localparam logic [2:0] REG_DIV  = 3'd3;
  localparam logic [2:0] REG_SEL  = 3'd4;

  // Strobes from the control block to the shift datapath
  typedef struct packed {
    logic start;   // clear bit counters
    logic txStep;  // launch next MOSI bit
    logic rxStep;  // capture MISO into the data register
    logic wrWord;  // host write of one data word
  } dpStrobe_t;

endpackage

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift
  import spi_ctl_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 stb,
  input  logic                      hiWord,
  input  logic [BUS_W-1:0]          wrData,
  input  logic [$clog2(DATA_W):0]   nBits,
  input  logic                      lsbFirst,
  input  logic                      miso,
  output logic [DATA_W-1:0]         dataQ,
  output logic                      mosi
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [CNT_W-1:0] txPosFull, rxPosFull;
  logic [LEN_W-1:0] txPos, rxPos;

  // Bit positions follow the selected order
  always_comb begin
    txPosFull = lsbFirst ? txCnt : (nBits - txCnt - CNT_ONE);
    rxPosFull = lsbFirst ? rxCnt : (nBits - rxCnt - CNT_ONE);
    txPos     = txPosFull[LEN_W-1:0];
    rxPos     = rxPosFull[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      mosi  <= 1'b0;
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      if (stb.start) begin
        txCnt <= '0;
        rxCnt <= '0;
      end
      if (stb.txStep) begin
        mosi  <= dataQ[txPos];
        txCnt <= txCnt + CNT_ONE;
      end
      if (stb.rxStep) begin
        dataQ[rxPos] <= miso;
        rxCnt        <= rxCnt + CNT_ONE;
      end
      if (stb.wrWord) begin
        if (hiWord) dataQ[DATA_W-1:BUS_W] <= wrData;
        else        dataQ[BUS_W-1:0]      <= wrData;
      end
    end
  end

endmodule

// File: rtl/spi_ctl_ctrl.sv
module spi_ctl_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DIV_W  = 16,
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [BUS_W-1:0]        busWrData,
  input  logic                    busWe,
  input  logic                    busStb,
  input  logic                    busCyc,
  output logic [BUS_W-1:0]        busRdData,
  output logic                    busAck,
  output logic                    irq,
  output logic                    sclk,
  output logic [SEL_W-1:0]        selN,
  output logic                    busy,
  output logic [$clog2(DATA_W):0] nBits,
  output logic                    lsbFirst,
  output dpStrobe_t               dpStb,
  output logic                    hiWord,
  input  logic [DATA_W-1:0]       dataQ
);
  localparam int LEN_W   = $clog2(DATA_W);
  localparam int CNT_W   = LEN_W + 1;
  localparam int HALF_W  = DIV_W + 2;
  localparam int BIT_GO  = 0;
  localparam int BIT_RXF = 1;
  localparam int BIT_TXF = 2;
  localparam int BIT_LEN = 3;
  localparam int BIT_LSB = BIT_LEN + LEN_W;
  localparam int BIT_IE  = BIT_LSB + 1;
  localparam logic [HALF_W-1:0] HALF_ONE = 1;
  localparam logic [CNT_W:0]    EDGE_ONE = 1;

  logic              rxFall, txFall, irqEn, justStarted;
  logic [LEN_W-1:0]  lenField;
  logic [DIV_W-1:0]  divReg;
  logic [SEL_W-1:0]  selReg;
  logic [HALF_W-1:0] clkCnt, halfLen;
  logic [CNT_W:0]    edgeCnt;
  logic [2:0]        regIdx;
  logic              aligned, acc, wr;
  logic              hitData, hitCtrl, hitDiv, hitSel;
  logic              startNow, tick, lastEdge;
  logic [BUS_W-1:0]  ctrlWord, rdMux;

  // Bus decode
  assign regIdx  = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign acc     = busStb && busCyc && !busAck;
  assign wr      = acc && busWe && aligned;
  assign hitData = (regIdx == REG_DLO) || (regIdx == REG_DHI);
  assign hitCtrl = (regIdx == REG_CTRL);
  assign hitDiv  = (regIdx == REG_DIV);
  assign hitSel  = (regIdx == REG_SEL);
  assign hiWord  = (regIdx == REG_DHI);
  assign startNow = wr && hitCtrl && !busy && busWrData[BIT_GO];

  // Serial clock timing
  assign halfLen  = ({2'b00, divReg} + HALF_ONE) << 1;
  assign nBits    = (lenField == '0) ? CNT_W'(DATA_W) : {1'b0, lenField};
  assign tick     = busy && (clkCnt == halfLen - HALF_ONE);
  assign lastEdge = (edgeCnt == ({nBits, 1'b0} - EDGE_ONE));

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_GO]              = busy;
    ctrlWord[BIT_RXF]             = rxFall;
    ctrlWord[BIT_TXF]             = txFall;
    ctrlWord[BIT_LEN +: LEN_W]    = lenField;
    ctrlWord[BIT_LSB]             = lsbFirst;
    ctrlWord[BIT_IE]              = irqEn;
  end

  always_comb begin
    rdMux = '0;
    if (aligned) begin
      case (regIdx)
        REG_DLO:  rdMux = dataQ[BUS_W-1:0];
        REG_DHI:  rdMux = dataQ[DATA_W-1:BUS_W];
        REG_CTRL: rdMux = ctrlWord;
        REG_DIV:  rdMux = {{(BUS_W-DIV_W){1'b0}}, divReg};
        REG_SEL:  rdMux = {{(BUS_W-SEL_W){1'b0}}, selReg};
        default:  rdMux = '0;
      endcase
    end
  end

  // Strobes to the datapath
  always_comb begin
    dpStb.start  = startNow;
    dpStb.txStep = (justStarted && txFall) ||
                   (txFall ? (tick && sclk && !lastEdge) : (tick && !sclk));
    dpStb.rxStep = rxFall ? (tick && sclk) : (tick && !sclk);
    dpStb.wrWord = wr && !busy && hitData;
  end

  assign selN = busy ? ~selReg : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAck      <= 1'b0;
      busRdData   <= '0;
      irq         <= 1'b0;
      sclk        <= 1'b0;
      busy        <= 1'b0;
      justStarted <= 1'b0;
      rxFall      <= 1'b0;
      txFall      <= 1'b0;
      lsbFirst    <= 1'b0;
      irqEn       <= 1'b0;
      lenField    <= '0;
      divReg      <= '0;
      selReg      <= '0;
      clkCnt      <= '0;
      edgeCnt     <= '0;
    end else begin
      busAck      <= acc;
      justStarted <= startNow;
      if (acc) busRdData <= rdMux;
      if (wr && hitSel) selReg <= busWrData[SEL_W-1:0];
      if (wr && hitDiv && !busy) divReg <= busWrData[DIV_W-1:0];
      if (wr && hitCtrl && !busy) begin
        rxFall   <= busWrData[BIT_RXF];
        txFall   <= busWrData[BIT_TXF];
        lenField <= busWrData[BIT_LEN +: LEN_W];
        lsbFirst <= busWrData[BIT_LSB];
        irqEn    <= busWrData[BIT_IE];
      end
      if (startNow) begin
        busy    <= 1'b1;
        clkCnt  <= '0;
        edgeCnt <= '0;
        sclk    <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          clkCnt  <= '0;
          sclk    <= ~sclk;
          edgeCnt <= edgeCnt + EDGE_ONE;
          if (lastEdge) busy <= 1'b0;
        end else begin
          clkCnt <= clkCnt + HALF_ONE;
        end
      end
      if (tick && lastEdge && irqEn) irq <= 1'b1;
      else if (busAck)               irq <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
  import spi_ctl_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DIV_W  = 16,
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busWe,
  input  logic              busStb,
  input  logic              busCyc,
  output logic [BUS_W-1:0]  busRdData,
  output logic              busAck,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SEL_W-1:0]  selN
);
  localparam int DATA_W = 2 * BUS_W;
  localparam int LEN_W  = $clog2(DATA_W);

  dpStrobe_t          dpStb;
  logic               busy, lsbFirst, hiWord;
  logic [LEN_W:0]     nBits;
  logic [DATA_W-1:0]  dataQ;

  spi_ctl_ctrl #(
    .BUS_W(BUS_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrData(busWrData), .busWe(busWe),
    .busStb(busStb), .busCyc(busCyc),
    .busRdData(busRdData), .busAck(busAck), .irq(irq),
    .sclk(sclk), .selN(selN), .busy(busy),
    .nBits(nBits), .lsbFirst(lsbFirst),
    .dpStb(dpStb), .hiWord(hiWord), .dataQ(dataQ)
  );

  spi_ctl_shift #(
    .BUS_W(BUS_W), .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk), .rstN(rstN),
    .stb(dpStb), .hiWord(hiWord), .wrData(busWrData),
    .nBits(nBits), .lsbFirst(lsbFirst), .miso(miso),
    .dataQ(dataQ), .mosi(mosi)
  );

endmodule

// File: rtl/spi_ctl_master_chk.sv
module spi_ctl_master_chk #(
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             sclk,
  input logic [SEL_W-1:0] selN,
  input logic             irq,
  input logic             busAck,
  input logic             busStb,
  input logic             busCyc
);

  // R2
  ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && busCyc && !busAck) |=> busAck);

  // R2
  ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R3
  sclk_moves_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> $past(busy));

  // R9
  busy_ends_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !sclk);

  // R10
  sel_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (selN == '1));

  // R11
  irq_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(busy));

  // R11
  irq_clear_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && !busy) |=> !irq);

endmodule

bind spi_ctl_master spi_ctl_master_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclk(sclk), .selN(selN),
  .irq(irq), .busAck(busAck), .busStb(busStb), .busCyc(busCyc)
);

// File: tb/spi_ctl_master_bench.sv
module spi_ctl_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWe = 1'b0, busStb = 1'b0, busCyc = 1'b0;
  logic [31:0] busRdData;
  logic        busAck, irq, sclk, mosi;
  logic        miso = 1'b0;
  logic [7:0]  selN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spi_ctl_master u_spi_ctl_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .busStb(busStb), .busCyc(busCyc), .busRdData(busRdData),
    .busAck(busAck), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .selN(selN)
  );

  // Slave model state
  logic [63:0] slvOut, slvIn;
  int  slvOutIdx, slvInIdx, risingCnt;
  bit  cfgTxFall, cfgRxFall;
  int  curHigh, firstHigh;

  always @(posedge sclk) begin
    risingCnt++;
    if (cfgTxFall) begin
      if (slvInIdx < 64) slvIn[slvInIdx] = mosi;
      slvInIdx++;
    end
    if (cfgRxFall) begin
      if (slvOutIdx < 64) miso = slvOut[slvOutIdx];
      slvOutIdx++;
    end
  end

  always @(negedge sclk) begin
    if (!cfgTxFall) begin
      if (slvInIdx < 64) slvIn[slvInIdx] = mosi;
      slvInIdx++;
    end
    if (!cfgRxFall) begin
      slvOutIdx++;
      if (slvOutIdx < 64) miso = slvOut[slvOutIdx];
    end
  end

  // High-phase width of the first SCLK pulse, in system clocks
  always @(negedge clk) begin
    if (sclk === 1'b1) curHigh++;
    else if (curHigh != 0) begin
      if (firstHigh == 0) firstHigh = curHigh;
      curHigh = 0;
    end
  end

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=150000", cycles);
      report();
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1; busStb = 1'b1; busCyc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 write ack", {63'b0, busAck}, 64'd1);
    busStb = 1'b0; busCyc = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0; busStb = 1'b1; busCyc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = busRdData;
    if (busAck !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R2 read ack: actual=%b expected=1", busAck);
    end
    busStb = 1'b0; busCyc = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 sclk", {63'b0, sclk}, 64'd0);
    check("R1 selN", {56'b0, selN}, 64'hFF);
    check("R1 irq", {63'b0, irq}, 64'd0);
    check("R1 ack", {63'b0, busAck}, 64'd0);
    busRead(5'h08, d); check("R1 ctrl", {32'b0, d}, 64'd0);
    busRead(5'h0C, d); check("R1 div", {32'b0, d}, 64'd0);
    busRead(5'h10, d); check("R1 sel", {32'b0, d}, 64'd0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    busWrite(5'h0C, 32'h5);
    busWrite(5'h10, 32'h81);
    busWrite(5'h08, 32'h40);
    busWrite(5'h00, 32'h12345678);
    busWrite(5'h04, 32'h9ABCDEF0);
    busRead(5'h0C, d); check("R2 div readback", {32'b0, d}, 64'h5);
    busRead(5'h10, d); check("R2 sel readback", {32'b0, d}, 64'h81);
    busRead(5'h08, d); check("R2 ctrl readback", {32'b0, d}, 64'h40);
    busRead(5'h00, d); check("R2 data low readback", {32'b0, d}, 64'h12345678);
    busRead(5'h04, d); check("R2 data high readback", {32'b0, d}, 64'h9ABCDEF0);
    busRead(5'h09, d); check("R2 misaligned read", {32'b0, d}, 64'h0);
    busRead(5'h18, d); check("R2 unmapped read", {32'b0, d}, 64'h0);
    check("R10 selects idle", {56'b0, selN}, 64'hFF);
  endtask

  task automatic xfer(input string tag, input logic [63:0] tx, input logic [63:0] slvWord,
                      input int len, input bit lsb, input bit txF, input bit rxF,
                      input bit ie, input int div, input logic [7:0] sel, input bit busyWrites);
    int n;
    int guard;
    logic [31:0] ctrl, d, lo, hi;
    logic [63:0] expData, expSlv, mask;
    n = (len == 0) ? 64 : len;
    expData = tx; expSlv = '0; mask = '0;
    for (int j = 0; j < n; j++) begin
      int pos;
      pos = lsb ? j : (n - 1 - j);
      expData[pos] = slvWord[j];
      expSlv[j] = tx[pos];
      mask[j] = 1'b1;
    end
    ctrl = '0;
    ctrl[10] = ie; ctrl[9] = lsb; ctrl[8:3] = len[5:0]; ctrl[2] = txF; ctrl[1] = rxF;

    busWrite(5'h0C, div[31:0]);
    busWrite(5'h10, {24'b0, sel});
    busWrite(5'h00, tx[31:0]);
    busWrite(5'h04, tx[63:32]);
    busWrite(5'h08, ctrl);
    // Slave setup
    cfgTxFall = txF; cfgRxFall = rxF;
    slvOut = slvWord; slvIn = '0; slvInIdx = 0; slvOutIdx = 0; risingCnt = 0;
    curHigh = 0; firstHigh = 0;
    if (!rxF) miso = slvWord[0];
    busWrite(5'h08, ctrl | 32'h1);
    check({tag, " R10 selects during transfer"}, {56'b0, selN}, {56'b0, ~sel});
    if (busyWrites) begin
      busWrite(5'h00, 32'hDEADBEEF);
      busWrite(5'h04, 32'hCAFEF00D);
      busWrite(5'h0C, 32'h0);
      busWrite(5'h08, 32'h41);
      busWrite(5'h10, 32'h5A);
      check({tag, " R12 select write while busy"}, {56'b0, selN}, 64'hA5);
    end
    if (ie) begin
      guard = 0;
      while (irq !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
      check({tag, " R11 irq raised"}, {63'b0, irq}, 64'd1);
      check({tag, " R10 selects released"}, {56'b0, selN}, 64'hFF);
      busRead(5'h08, d);
      check({tag, " R9 busy cleared"}, {63'b0, d[0]}, 64'd0);
      check({tag, " R11 irq held through ack"}, {63'b0, irq}, 64'd1);
      @(negedge clk);
      check({tag, " R11 irq cleared after access"}, {63'b0, irq}, 64'd0);
    end else begin
      busRead(5'h08, d);
      check({tag, " R9 busy set"}, {63'b0, d[0]}, 64'd1);
      guard = 0;
      while (d[0] && guard < 20000) begin busRead(5'h08, d); guard++; end
      check({tag, " R9 busy cleared"}, {63'b0, d[0]}, 64'd0);
      check({tag, " R11 irq stays low when disabled"}, {63'b0, irq}, 64'd0);
    end
    check({tag, " R12 ctrl unchanged"}, {32'b0, d}, {32'b0, ctrl});
    busRead(5'h0C, d);
    check({tag, " R12 divider unchanged"}, {32'b0, d}, div);
    busRead(5'h00, lo);
    busRead(5'h04, hi);
    check({tag, lsb ? " R6 received word" : " R5 received word"}, {hi, lo}, expData);
    check({tag, txF ? " R7 slave got MOSI (fall launch)" : " R7 slave got MOSI (rise launch)"},
          slvIn & mask, expSlv);
    check({tag, rxF ? " R8 capture on falling" : " R8 capture on rising"},
          {hi, lo} & mask, expData & mask);
    check({tag, " R4 rising edge count"}, 64'(risingCnt), 64'(n));
    check({tag, " R3 half period"}, 64'(firstHigh), 64'((div + 1) * 2));
    check({tag, " R3 sclk idle low"}, {63'b0, sclk}, 64'd0);
  endtask

  initial begin
    cfgTxFall = 0; cfgRxFall = 0; slvOut = '0; slvIn = '0;
    slvOutIdx = 0; slvInIdx = 0; risingCnt = 0; curHigh = 0; firstHigh = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    xfer("A8", 64'h0000_0000_0000_005A, 64'h0000_0000_0000_00C3, 8,  0, 0, 1, 0, 5, 8'h01, 0);
    xfer("B8", 64'h1111_2222_3333_44A5, 64'h0000_0000_0000_0096, 8,  0, 1, 0, 0, 0, 8'h01, 0);
    xfer("C16", 64'h0000_0000_0000_5AA5, 64'h0000_0000_0000_E1F0, 16, 1, 1, 0, 0, 1, 8'h02, 0);
    xfer("D1", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1,  0, 0, 0, 0, 2, 8'h80, 0);
    xfer("E64", 64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687, 0,  0, 1, 1, 1, 0, 8'h01, 0);
    xfer("F32", 64'hAA55_A5A5_0F0F_3C3C, 64'h0000_0000_8421_7BDE, 32, 1, 0, 0, 1, 0, 8'hA5, 1);
    report();
  end

endmodule